// File: doc/BRIEF.md
# Serial ADC Device Port Model

This block is a synthesizable stand-in for the digital side of a successive-approximation converter's serial port. It lets a host controller be tested against a realistic target. The host drives an active-low chip select and a serial clock. The block runs on a fast system clock and passes both of those inputs through a two-flop synchronizer before it looks for edges. When chip select falls, the block captures a parallel sample word and the resolution setting. It then leaves high impedance and drives a frame onto a single serial data line. The frame is four zero bits followed by the sample, most significant bit first, in straight binary. Each falling edge of the serial clock advances the frame by one bit.

The resolution is picked per frame: 12-bit frames have 16 bit times and 10-bit frames have 14. The line is released after the falling edge that closes the frame. If chip select rises early, the rest of the frame is dropped and the line is released at once. A monitor counts system cycles from each release. It flags any new chip-select fall that arrives before a parameterized quiet interval has passed.

The controller has three states. ST_IDLE means chip select is high and the line is released. ST_SHIFT means a frame is being driven. ST_DONE means the frame is complete but chip select is still low. The transitions are:
- ST_IDLE to ST_SHIFT on a chip-select fall.
- ST_SHIFT to ST_DONE on the falling serial-clock edge that closes the frame.
- ST_SHIFT to ST_IDLE on a chip-select rise (abort).
- ST_DONE to ST_IDLE on a chip-select rise.

Top module: `adcp_port_model`

## Requirements
- R1: After reset, `sdata_oe` is 0, `sdata` is high impedance and `quiet_violation` is 0.
- R2: A falling edge on `cs_n` turns `sdata_oe` on, and the first bit driven is 0.
- R3: Each falling `sclk` edge inside a frame moves to the next bit. Bits 0 to 3 of a frame are 0, and the sample then follows MSB first.
- R4: With `short_res` = 0, the frame carries `sample_word[11:0]` in frame bits 4 to 15. The line is released on the 16th falling `sclk` edge.
- R5: With `short_res` = 1, the frame carries `sample_word[9:0]` in frame bits 4 to 13, and bits 11:10 are ignored. The line is released on the 14th falling `sclk` edge.
- R6: `sample_word` and `short_res` are captured at the `cs_n` fall. Later changes to them do not alter the frame in progress.
- R7: A rising `cs_n` edge before the frame ends releases the line, and the rest of the frame is discarded. `sclk` edges while `cs_n` is high leave the line released.
- R8: After a frame ends, further `sclk` falling edges with `cs_n` still low leave the line released.
- R9: `quiet_violation` pulses for one cycle, together with the output enable turning on, when `cs_n` falls less than `QUIET_CYCLES` system cycles after the line was last released. It stays 0 when the gap is at least that long.
- R10: Both inputs pass through a two-flop synchronizer. An output change appears on the third system clock edge after an input edge, and not on the second.
- R11: `sdata` is high impedance whenever `sdata_oe` is 0, and otherwise carries the current frame bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `sclk` |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Serial clock from the host; bits advance on its falling edge |
| sample_word | input | 12 | Parallel sample, straight binary |
| short_res | input | 1 | 1 selects 10-bit frames, 0 selects 12-bit frames |
| sdata | output | 1 | Three-state serial data line |
| sdata_oe | output | 1 | High while the block drives `sdata` |
| quiet_violation | output | 1 | One-cycle pulse on a chip-select fall that breaks the quiet interval |

## Verification
Some properties are checked by assertions on every cycle:
- The enable turns on only after a chip-select fall.
- The enable is off whenever synchronized chip select is high, and in ST_DONE.
- The four leading bits are zero.
- The bit counter never leaves the frame.
- Synchronized edge pulses last a single cycle.
- A quiet violation occurs only together with a chip-select fall.

Other behaviour can only be shown by the bench's scenarios:
- The exact bit sequence for given sample words in both resolutions.
- Sample capture at the chip-select fall, and the ignored upper bits in 10-bit mode.
- Release on the last edge and abort on an early rise.
- The three-cycle latency.
- The quiet flag appearing or not, depending on the measured gap.

// File: rtl/adcp_pkg.sv
package adcp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_DONE  = 2'd2
    } port_state_t;

endpackage

// File: rtl/adcp_edge_sync.sv
module adcp_edge_sync #(
    parameter int   STAGES  = 2,
    parameter logic IDLE_LV = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level_o,
    output logic fall_o,
    output logic rise_o
);

    logic [STAGES:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[0] <= IDLE_LV;
        else        chain_q[0] <= async_in;
    end

    for (genvar g = 1; g <= STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[g] <= IDLE_LV;
            else        chain_q[g] <= chain_q[g-1];
        end
    end

    assign level_o = chain_q[STAGES-1];
    assign fall_o  = chain_q[STAGES] & ~chain_q[STAGES-1];
    assign rise_o  = ~chain_q[STAGES] & chain_q[STAGES-1];

    // R10
    fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);

    // R10
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/adcp_frame_fsm.sv
module adcp_frame_fsm
    import adcp_pkg::*;
#(
    parameter int HI_BITS = 12,
    parameter int LO_BITS = 10,
    parameter int LEAD    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_level,
    input  logic               cs_fall,
    input  logic               cs_rise,
    input  logic               sclk_fall,
    input  logic [HI_BITS-1:0] sample_word,
    input  logic               short_mode,
    output logic               bit_o,
    output logic               oe_o,
    output logic               release_o
);

    localparam int HI_LEN = LEAD + HI_BITS;
    localparam int LO_LEN = LEAD + LO_BITS;
    localparam int CW     = $clog2(HI_LEN + 1);
    localparam int IW     = $clog2(HI_BITS);

    port_state_t        state_q, state_d;
    logic [HI_BITS-1:0] word_q;
    logic               short_q;
    logic [CW-1:0]      cnt_q;
    logic               oe_q, bit_q, release_q;
    logic [CW-1:0]      last_idx;
    logic               at_last;

    assign last_idx = short_q ? CW'(LO_LEN - 1) : CW'(HI_LEN - 1);
    assign at_last  = (cnt_q == last_idx);

    function automatic logic pick_bit(input logic [HI_BITS-1:0] w,
                                      input logic s,
                                      input logic [CW-1:0] k);
        int pos;
        pos = (s ? LO_BITS : HI_BITS) - 1 - (int'(k) - LEAD);
        if (int'(k) < LEAD || pos < 0 || pos >= HI_BITS) return 1'b0;
        return w[IW'(pos)];
    endfunction

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cs_fall) state_d = ST_SHIFT;
            ST_SHIFT: begin
                if (cs_rise)                    state_d = ST_IDLE;
                else if (sclk_fall && at_last)  state_d = ST_DONE;
            end
            ST_DONE:  if (cs_rise) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q    <= '0;
            short_q   <= 1'b0;
            cnt_q     <= '0;
            oe_q      <= 1'b0;
            bit_q     <= 1'b0;
            release_q <= 1'b0;
        end else begin
            release_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (cs_fall) begin
                        word_q  <= sample_word;
                        short_q <= short_mode;
                        cnt_q   <= '0;
                        oe_q    <= 1'b1;
                        bit_q   <= 1'b0;
                    end
                end
                ST_SHIFT: begin
                    if (cs_rise) begin
                        oe_q      <= 1'b0;
                        bit_q     <= 1'b0;
                        release_q <= 1'b1;
                    end else if (sclk_fall) begin
                        if (at_last) begin
                            oe_q      <= 1'b0;
                            bit_q     <= 1'b0;
                            release_q <= 1'b1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                            bit_q <= pick_bit(word_q, short_q, cnt_q + 1'b1);
                        end
                    end
                end
                ST_DONE: begin
                end
                default: begin
                    oe_q <= 1'b0;
                end
            endcase
        end
    end

    assign bit_o     = bit_q;
    assign oe_o      = oe_q;
    assign release_o = release_q;

    // R2
    oe_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_q) |-> $past(cs_fall));

    // R7
    cs_high_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_level |=> !oe_q);

    // R3
    lead_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_q && (cnt_q < CW'(LEAD))) |-> !bit_q);

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_q |-> (cnt_q <= last_idx));

    // R8
    done_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |-> !oe_q);

endmodule

// File: rtl/adcp_quiet_mon.sv
module adcp_quiet_mon #(
    parameter int QUIET_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic release_i,
    input  logic cs_fall,
    output logic violation_o
);

    localparam int QW = $clog2(QUIET_CYCLES + 1);
    localparam logic [QW-1:0] QMAX = QW'(QUIET_CYCLES);

    logic [QW-1:0] gap_q;
    logic          viol_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= QMAX;
            viol_q <= 1'b0;
        end else begin
            viol_q <= cs_fall && (gap_q < QMAX);
            if (release_i)         gap_q <= '0;
            else if (gap_q < QMAX) gap_q <= gap_q + 1'b1;
        end
    end

    assign violation_o = viol_q;

    // R9
    viol_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        violation_o |-> $past(cs_fall));

    // R9
    gap_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gap_q <= QMAX);

endmodule

// File: rtl/adcp_port_model.sv
module adcp_port_model #(
    parameter int RES_HI       = 12,
    parameter int RES_LO       = 10,
    parameter int LEAD_ZEROS   = 4,
    parameter int SYNC_STAGES  = 2,
    parameter int QUIET_CYCLES = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic [RES_HI-1:0] sample_word,
    input  logic              short_res,
    output logic              sdata,
    output logic              sdata_oe,
    output logic              quiet_violation
);

    logic cs_level, cs_fall, cs_rise;
    logic sclk_level, sclk_fall, sclk_rise;
    logic bit_w, oe_w, release_w;

    adcp_edge_sync #(.STAGES(SYNC_STAGES), .IDLE_LV(1'b1)) u_cs_sync (
        .clk(clk), .rst_n(rst_n), .async_in(cs_n),
        .level_o(cs_level), .fall_o(cs_fall), .rise_o(cs_rise)
    );

    adcp_edge_sync #(.STAGES(SYNC_STAGES), .IDLE_LV(1'b1)) u_sclk_sync (
        .clk(clk), .rst_n(rst_n), .async_in(sclk),
        .level_o(sclk_level), .fall_o(sclk_fall), .rise_o(sclk_rise)
    );

    adcp_frame_fsm #(.HI_BITS(RES_HI), .LO_BITS(RES_LO), .LEAD(LEAD_ZEROS)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cs_level(cs_level), .cs_fall(cs_fall), .cs_rise(cs_rise),
        .sclk_fall(sclk_fall),
        .sample_word(sample_word), .short_mode(short_res),
        .bit_o(bit_w), .oe_o(oe_w), .release_o(release_w)
    );

    adcp_quiet_mon #(.QUIET_CYCLES(QUIET_CYCLES)) u_quiet (
        .clk(clk), .rst_n(rst_n),
        .release_i(release_w), .cs_fall(cs_fall),
        .violation_o(quiet_violation)
    );

    assign sdata    = oe_w ? bit_w : 1'bz;
    assign sdata_oe = oe_w;

    // R11
    drive_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sdata_oe |-> (sdata === bit_w));

    // R7
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_rise && cs_level) |=> !sdata_oe);

endmodule

// File: tb/adcp_port_model_bench.sv
module adcp_port_model_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b1;
    logic [11:0] sample_word = '0;
    logic        short_res = 1'b0;
    wire         sdata;
    wire         sdata_oe;
    wire         quiet_violation;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adcp_port_model u_adcp_port_model (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
        .sample_word(sample_word), .short_res(short_res),
        .sdata(sdata), .sdata_oe(sdata_oe), .quiet_violation(quiet_violation)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    function automatic logic exp_bit(input logic [11:0] w, input bit ten, input int k);
        if (k < 4) return 1'b0;
        return ten ? w[9-(k-4)] : w[11-(k-4)];
    endfunction

    // R3, R4, R5, R6: one whole frame, checking each bit and the release
    task automatic run_frame(input logic [11:0] w, input bit ten, input bit disturb);
        int len;
        len = ten ? 14 : 16;
        sample_word = w; short_res = ten;
        cs_n = 1'b0; wait_clk(3);
        check("R2 oe on", sdata_oe, 1'b1);
        check("R2 first bit", sdata, 1'b0);
        for (int k = 1; k < len; k++) begin
            sclk = 1'b0; wait_clk(3);
            check(ten ? "R5 bit" : "R3/R4 bit", sdata, exp_bit(w, ten, k));
            wait_clk(5);
            sclk = 1'b1; wait_clk(8);
            if (disturb && k == 5) begin
                sample_word = ~w; short_res = ~ten;
            end
        end
        sclk = 1'b0; wait_clk(3);
        check(ten ? "R5 release" : "R4 release", sdata_oe, 1'b0);
        check("R11 z after frame", sdata, 1'bz);
        wait_clk(5); sclk = 1'b1; wait_clk(8);
        // R8: more edges with cs low
        sclk = 1'b0; wait_clk(8);
        check("R8 stays off", sdata_oe, 1'b0);
        sclk = 1'b1; wait_clk(8);
        cs_n = 1'b1; wait_clk(30);
        check("R11 z idle", sdata, 1'bz);
    endtask

    task automatic t_reset;
        check("R1 oe", sdata_oe, 1'b0);
        check("R1 sdata z", sdata, 1'bz);
        check("R1 violation", quiet_violation, 1'b0);
    endtask

    task automatic t_latency;
        sample_word = 12'h800; short_res = 1'b0;
        cs_n = 1'b0; wait_clk(8);
        for (int k = 1; k < 4; k++) begin
            sclk = 1'b0; wait_clk(8); sclk = 1'b1; wait_clk(8);
        end
        sclk = 1'b0; wait_clk(2);
        check("R10 not yet", sdata, 1'b0);
        wait_clk(1);
        check("R10 third edge", sdata, 1'b1);
        wait_clk(5); sclk = 1'b1; wait_clk(8);
        // R7 abort mid-frame
        cs_n = 1'b1; wait_clk(3);
        check("R7 abort release", sdata_oe, 1'b0);
        sclk = 1'b0; wait_clk(8);
        check("R7 sclk while cs high", sdata_oe, 1'b0);
        sclk = 1'b1; wait_clk(30);
        check("R7 still off", sdata, 1'bz);
    endtask

    task automatic t_quiet;
        sample_word = 12'h123; short_res = 1'b1;
        cs_n = 1'b0; wait_clk(8);
        for (int k = 1; k < 14; k++) begin
            sclk = 1'b0; wait_clk(8); sclk = 1'b1; wait_clk(8);
        end
        sclk = 1'b0; wait_clk(3);
        check("R9 released", sdata_oe, 1'b0);
        sclk = 1'b1;
        cs_n = 1'b1; wait_clk(4);
        cs_n = 1'b0; wait_clk(3);
        check("R9 violation", quiet_violation, 1'b1);
        check("R9 frame still starts", sdata_oe, 1'b1);
        wait_clk(1);
        check("R9 one-cycle pulse", quiet_violation, 1'b0);
        cs_n = 1'b1; wait_clk(40);
        cs_n = 1'b0; wait_clk(3);
        check("R9 no violation", quiet_violation, 1'b0);
        check("R2 oe after gap", sdata_oe, 1'b1);
        cs_n = 1'b1; wait_clk(40);
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        run_frame(12'hA5C, 1'b0, 1'b0);
        run_frame(12'h3C9, 1'b0, 1'b0);
        run_frame(12'hD5A, 1'b1, 1'b0);
        run_frame(12'h6B3, 1'b0, 1'b1);  // R6 disturbed inputs mid-frame
        t_latency();
        t_quiet();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

endmodule